// File: doc/BRIEF.md
# AES-128 Inverse Round Stage

This block performs one round of AES-128 decryption on a 128-bit state. A chain of eleven copies (or one copy fed eleven times) turns a ciphertext back into its plaintext. Each accepted input carries the state, the round key for that step and a round number. The block registers the result and raises a one-cycle completion pulse, which the next stage takes as its own enable. The pulse carries the same round number forward.

Round number 0 is the whitening step: the ciphertext is XORed with the final key of the expansion (words 40 to 43). Rounds 1 to 9 apply four steps in order: inverse row rotation, inverse byte substitution, round-key XOR, then inverse column mixing. Round 10 omits the column mixing. Decryption round r takes its key from schedule round 10 - r. The stage can accept a new input on every clock cycle.

Top module: `aes_dec_round_stage`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0, `out_state` is all zeros and `out_round` is 0.
- R2: A high `in_valid` at a rising edge gives `out_valid` high for exactly the following cycle. `out_valid` never rises without a preceding enable.
- R3: When `in_round` is 0, the result is `in_state ^ in_key`.
- R4: When `in_round` is 1 to 9, the result is InvMixColumns(InvSubBytes(InvShiftRows(`in_state`)) ^ `in_key`).
- R5: When `in_round` is 10, the result is InvSubBytes(InvShiftRows(`in_state`)) ^ `in_key`, with no column mixing.
- R6: State byte i occupies bits [127-8i : 120-8i], with row i mod 4 and column i div 4. Inverse row rotation moves row r right by r byte positions; row 0 stays in place.
- R7: Inverse substitution is the inverse of the standard AES S-box: 0x00 maps to 0x52 and 0x63 maps to 0x00. Zero state and zero key at round 10 therefore give 0x52 in every byte.
- R8: `out_round` equals the `in_round` of the input that produced the result.
- R9: When `in_valid` is low, `out_state` and `out_round` hold their values.
- R10: Enables on consecutive cycles are each accepted, with one result per cycle in input order.
- R11: Starting from an AES-128 ciphertext, eleven passes with rounds 0 to 10 and keys from schedule rounds 10 down to 0 reproduce the plaintext.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Enable pulse from the previous stage |
| in_round | input | 4 | Decryption round number, 0 to 10 |
| in_state | input | 128 | State entering the round |
| in_key | input | 128 | Round key for this step |
| out_valid | output | 1 | Completion pulse, enables the next stage |
| out_round | output | 4 | Round number carried with the result |
| out_state | output | 128 | State leaving the round |

## Verification
Two things can happen in the same clock cycle: the stage emits the completion pulse for one input while it accepts the next enable, which may request a different round type. The bench provokes this by issuing enables on consecutive cycles with no gap. It mixes whitening, full and final rounds in one burst. A behavioural model written with byte matrices and a brute-force inverse S-box predicts each output. The bench compares the output with the model on every clock, so a result that is lost, stale or mistyped at a round change shows up as a miscompare in that cycle.

// File: rtl/aes_inv_pkg.sv
package aes_inv_pkg;
  localparam int BYTE_W  = 8;
  localparam int NROW    = 4;
  localparam int NCOL    = 4;
  localparam int NBYTES  = NROW * NCOL;
  localparam int COL_W   = NROW * BYTE_W;
  localparam int STATE_W = NBYTES * BYTE_W;

  // multiply in GF(2^8) modulo x^8+x^4+x^3+x+1
  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] p;
    acc = 8'h00;
    p   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ p;
      p = {p[6:0], 1'b0} ^ (p[7] ? 8'h1b : 8'h00);
    end
    return acc;
  endfunction

  // multiplicative inverse as a^254 (zero maps to zero)
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] r;
    logic [7:0] p;
    logic [7:0] e;
    r = 8'h01;
    p = a;
    e = 8'd254;
    for (int i = 0; i < 8; i++) begin
      if (e[i]) r = gf_mul(r, p);
      p = gf_mul(p, p);
    end
    return r;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] b, input int n);
    logic [15:0] d;
    d = {b, b} << n;
    return d[15:8];
  endfunction

  // undo the affine map of the forward substitution
  function automatic logic [7:0] inv_affine(input logic [7:0] b);
    return rotl8(b, 1) ^ rotl8(b, 3) ^ rotl8(b, 6) ^ 8'h05;
  endfunction

  function automatic logic [7:0] inv_sbox(input logic [7:0] b);
    return gf_inv(inv_affine(b));
  endfunction

  // one column of the inverse mixing matrix, byte 0 in the top bits
  function automatic logic [COL_W-1:0] inv_mix_col(input logic [COL_W-1:0] col);
    logic [7:0] a0, a1, a2, a3;
    logic [7:0] o0, o1, o2, o3;
    a0 = col[31:24];
    a1 = col[23:16];
    a2 = col[15:8];
    a3 = col[7:0];
    o0 = gf_mul(a0, 8'h0e) ^ gf_mul(a1, 8'h0b) ^ gf_mul(a2, 8'h0d) ^ gf_mul(a3, 8'h09);
    o1 = gf_mul(a0, 8'h09) ^ gf_mul(a1, 8'h0e) ^ gf_mul(a2, 8'h0b) ^ gf_mul(a3, 8'h0d);
    o2 = gf_mul(a0, 8'h0d) ^ gf_mul(a1, 8'h09) ^ gf_mul(a2, 8'h0e) ^ gf_mul(a3, 8'h0b);
    o3 = gf_mul(a0, 8'h0b) ^ gf_mul(a1, 8'h0d) ^ gf_mul(a2, 8'h09) ^ gf_mul(a3, 8'h0e);
    return {o0, o1, o2, o3};
  endfunction
endpackage

// File: rtl/aes_inv_shift_rows.sv
module aes_inv_shift_rows
  import aes_inv_pkg::*;
(
  input  logic [STATE_W-1:0] state_i,
  output logic [STATE_W-1:0] state_o
);
  // R6: row r moves right by r positions, byte (r,c) at index r + NROW*c
  for (genvar r = 0; r < NROW; r++) begin : g_row
    for (genvar c = 0; c < NCOL; c++) begin : g_col
      localparam int DST = r + NROW * c;
      localparam int SRC = r + NROW * ((c - r + NCOL) % NCOL);
      assign state_o[STATE_W-1-BYTE_W*DST -: BYTE_W] = state_i[STATE_W-1-BYTE_W*SRC -: BYTE_W];
    end
  end
endmodule

// File: rtl/aes_inv_sub_bytes.sv
module aes_inv_sub_bytes
  import aes_inv_pkg::*;
(
  input  logic [STATE_W-1:0] state_i,
  output logic [STATE_W-1:0] state_o
);
  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    assign state_o[STATE_W-1-BYTE_W*i -: BYTE_W] = inv_sbox(state_i[STATE_W-1-BYTE_W*i -: BYTE_W]);
  end
endmodule

// File: rtl/aes_inv_mix_cols.sv
module aes_inv_mix_cols
  import aes_inv_pkg::*;
(
  input  logic [STATE_W-1:0] state_i,
  output logic [STATE_W-1:0] state_o
);
  for (genvar c = 0; c < NCOL; c++) begin : g_col
    assign state_o[STATE_W-1-COL_W*c -: COL_W] = inv_mix_col(state_i[STATE_W-1-COL_W*c -: COL_W]);
  end
endmodule

// File: rtl/aes_dec_round_stage.sv
module aes_dec_round_stage
  import aes_inv_pkg::*;
#(
  parameter int ROUND_W    = 4,
  parameter int LAST_ROUND = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [ROUND_W-1:0] in_round,
  input  logic [STATE_W-1:0] in_state,
  input  logic [STATE_W-1:0] in_key,
  output logic               out_valid,
  output logic [ROUND_W-1:0] out_round,
  output logic [STATE_W-1:0] out_state
);
  localparam logic [ROUND_W-1:0] LAST_R  = ROUND_W'(LAST_ROUND);
  localparam logic [ROUND_W-1:0] WHITE_R = '0;

  logic [STATE_W-1:0] shift_state;
  logic [STATE_W-1:0] sub_state;
  logic [STATE_W-1:0] keyed_state;
  logic [STATE_W-1:0] mix_state;
  logic [STATE_W-1:0] next_state;
  logic               whiten_evt;
  logic               last_evt;

  aes_inv_shift_rows u_shift (.state_i(in_state),    .state_o(shift_state));
  aes_inv_sub_bytes  u_sub   (.state_i(shift_state), .state_o(sub_state));

  assign keyed_state = sub_state ^ in_key;

  aes_inv_mix_cols   u_mix   (.state_i(keyed_state), .state_o(mix_state));

  assign whiten_evt = in_valid && (in_round == WHITE_R);
  assign last_evt   = in_valid && (in_round == LAST_R);

  always_comb begin
    if (in_round == WHITE_R)     next_state = in_state ^ in_key;
    else if (in_round == LAST_R) next_state = keyed_state;
    else                         next_state = mix_state;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_round <= '0;
      out_state <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_round <= in_round;
        out_state <= next_state;
      end
    end
  end
endmodule

// File: rtl/aes_dec_round_chk.sv
module aes_dec_round_chk
  import aes_inv_pkg::*;
#(
  parameter int ROUND_W    = 4,
  parameter int LAST_ROUND = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [ROUND_W-1:0] in_round,
  input logic [STATE_W-1:0] in_state,
  input logic [STATE_W-1:0] in_key,
  input logic [STATE_W-1:0] sub_state,
  input logic               whiten_evt,
  input logic               last_evt,
  input logic               out_valid,
  input logic [ROUND_W-1:0] out_round,
  input logic [STATE_W-1:0] out_state
);
  always_comb begin
    if (!rst_n) begin
      AST_RESET_CLEAR: assert (!out_valid && out_state == '0 && out_round == '0); // R1
    end
  end

  AST_DONE_FOLLOWS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R2
  AST_WHITEN_XOR: assert property (@(posedge clk) disable iff (!rst_n)
    whiten_evt |=> out_state == $past(in_state ^ in_key)); // R3
  AST_LAST_NO_MIX: assert property (@(posedge clk) disable iff (!rst_n)
    last_evt |=> out_state == $past(sub_state ^ in_key)); // R5
  AST_ROUND_CARRIED: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_round == $past(in_round)); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_state) && $stable(out_round)); // R9
endmodule

bind aes_dec_round_stage aes_dec_round_chk #(
  .ROUND_W(ROUND_W), .LAST_ROUND(LAST_ROUND)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_round(in_round),
  .in_state(in_state), .in_key(in_key), .sub_state(sub_state),
  .whiten_evt(whiten_evt), .last_evt(last_evt),
  .out_valid(out_valid), .out_round(out_round), .out_state(out_state)
);

// File: tb/test_aes_dec_round_stage.sv
module test_aes_dec_round_stage;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [3:0]   in_round = '0;
  logic [127:0] in_state = '0;
  logic [127:0] in_key = '0;
  logic         out_valid;
  logic [3:0]   out_round;
  logic [127:0] out_state;

  int nvec = 0;
  int nbad = 0;
  bit done = 0;

  logic [7:0]   fwd_tab [256];
  logic [7:0]   inv_tab [256];
  logic [127:0] rk [11];
  logic [127:0] last_out = '0;
  logic [3:0]   last_rnd = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aes_dec_round_stage i_aes_dec_round_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_round(in_round),
    .in_state(in_state), .in_key(in_key), .out_valid(out_valid),
    .out_round(out_round), .out_state(out_state)
  );

  // ---------------- reference arithmetic ----------------
  function automatic logic [7:0] xt(input logic [7:0] a);
    return (a << 1) ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc = 0;
    for (int i = 7; i >= 0; i--) acc = xt(acc) ^ (b[i] ? a : 8'h00);
    return acc;
  endfunction

  function automatic logic [7:0] rl(input logic [7:0] b, input int n);
    return (b << n) | (b >> (8 - n));
  endfunction

  function automatic logic [7:0] getb(input logic [127:0] s, input int r, input int c);
    return s[127 - 8*(r + 4*c) -: 8];
  endfunction

  function automatic logic [127:0] inv_round(input logic [127:0] s, input logic [127:0] k, input int rnd);
    logic [7:0] m [4][4];
    logic [7:0] t [4][4];
    logic [7:0] cf [4];
    logic [127:0] o;
    cf = '{8'h0e, 8'h0b, 8'h0d, 8'h09};
    if (rnd == 0) return s ^ k;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        t[r][(c + r) % 4] = inv_tab[getb(s, r, c)];
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        t[r][c] = t[r][c] ^ getb(k, r, c);
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) begin
        m[r][c] = t[r][c];
        if (rnd != 10) begin
          m[r][c] = 0;
          for (int q = 0; q < 4; q++) m[r][c] = m[r][c] ^ mul(cf[(q - r + 4) % 4], t[q][c]);
        end
      end
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) o[127 - 8*(r + 4*c) -: 8] = m[r][c];
    return o;
  endfunction

  function automatic logic [127:0] fwd_round(input logic [127:0] s, input logic [127:0] k, input bit mix);
    logic [7:0] t [4][4];
    logic [7:0] m [4][4];
    logic [7:0] cf [4];
    logic [127:0] o;
    cf = '{8'h02, 8'h03, 8'h01, 8'h01};
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) t[r][c] = fwd_tab[getb(s, r, (c + r) % 4)];
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) begin
        m[r][c] = t[r][c];
        if (mix) begin
          m[r][c] = 0;
          for (int q = 0; q < 4; q++) m[r][c] = m[r][c] ^ mul(cf[(q - r + 4) % 4], t[q][c]);
        end
      end
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) o[127 - 8*(r + 4*c) -: 8] = m[r][c] ^ getb(k, r, c);
    return o;
  endfunction

  task automatic build_tables();
    for (int x = 0; x < 256; x++) begin
      logic [7:0] iv = 0;
      logic [7:0] s;
      for (int y = 1; y < 256; y++) if (x != 0 && mul(8'(x), 8'(y)) == 8'h01) iv = 8'(y);
      s = iv ^ rl(iv, 1) ^ rl(iv, 2) ^ rl(iv, 3) ^ rl(iv, 4) ^ 8'h63;
      fwd_tab[x] = s;
    end
    for (int x = 0; x < 256; x++) inv_tab[fwd_tab[x]] = 8'(x);
  endtask

  task automatic expand(input logic [127:0] key);
    logic [31:0] w [44];
    logic [7:0]  rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = key[127 - 32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      logic [31:0] t = w[i-1];
      if (i % 4 == 0) begin
        t = {t[23:0], t[31:24]};
        t = {fwd_tab[t[31:24]], fwd_tab[t[23:16]], fwd_tab[t[15:8]], fwd_tab[t[7:0]]};
        t = t ^ {rc, 24'h0};
        rc = xt(rc);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r < 11; r++) rk[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
  endtask

  function automatic logic [127:0] encrypt(input logic [127:0] pt);
    logic [127:0] s = pt ^ rk[0];
    for (int r = 1; r <= 10; r++) s = fwd_round(s, rk[r], r != 10);
    return s;
  endfunction

  // ---------------- checking ----------------
  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one cycle; compare outputs at the following falling edge
  task automatic step(input bit v, input logic [127:0] st, input logic [127:0] k, input int rnd, input string tag);
    logic [127:0] exp_s;
    logic [3:0]   exp_r;
    in_valid = v;
    in_state = st;
    in_key   = k;
    in_round = 4'(rnd);
    exp_s = v ? inv_round(st, k, rnd) : last_out;
    exp_r = v ? 4'(rnd) : last_rnd;
    @(posedge clk);
    @(negedge clk);
    chk(out_valid == v, {tag, " R2 valid"}, 128'(out_valid), 128'(v));
    chk(out_state == exp_s, tag, out_state, exp_s);
    chk(out_round == exp_r, {tag, " R8 round"}, 128'(out_round), 128'(exp_r));
    last_out = out_state;
    last_rnd = out_round;
  endtask

  task automatic round_trip(input logic [127:0] key, input logic [127:0] pt);
    logic [127:0] s;
    expand(key);
    s = encrypt(pt);
    for (int r = 0; r <= 10; r++) begin
      step(1, s, rk[10 - r], r, r == 0 ? "R3 whiten" : (r == 10 ? "R5 last" : "R4 R6 full"));
      s = out_state;
    end
    chk(s == pt, "R11 round trip", s, pt);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nbad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    if (!done) begin
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    logic [127:0] ct;
    build_tables();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(out_valid == 1'b0, "R1 valid", 128'(out_valid), 0);
    chk(out_state == '0, "R1 state", out_state, 0);
    chk(out_round == '0, "R1 round", 128'(out_round), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // known-answer ciphertext, then decrypt through 11 passes
    expand(128'h000102030405060708090a0b0c0d0e0f);
    ct = encrypt(128'h00112233445566778899aabbccddeeff);
    chk(ct == 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R11 ciphertext", ct,
        128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    round_trip(128'h000102030405060708090a0b0c0d0e0f, 128'h00112233445566778899aabbccddeeff);

    // R7: inverse substitution of zero, round 10, zero key
    step(1, '0, '0, 10, "R7 sbox");
    chk(out_state == {16{8'h52}}, "R7 sbox constant", out_state, {16{8'h52}});
    // R6: distinct bytes through the last round, zero key
    step(1, 128'h00112233445566778899aabbccddeeff, '0, 10, "R6 rotate");

    // R9: idle cycles with changing inputs hold the result
    step(0, 128'hdeadbeef_00000000_12345678_9abcdef0, 128'hffff, 3, "R9 hold");
    step(0, '1, '1, 0, "R9 hold");

    // R10: back-to-back enables mixing round kinds
    step(1, 128'h0123456789abcdeffedcba9876543210, 128'h55aa, 0, "R10 R3 b2b");
    step(1, 128'hcafebabe_01020304_a5a5a5a5_77777777, 128'h1234, 10, "R10 R5 b2b");
    step(1, 128'h0f0e0d0c0b0a09080706050403020100, 128'h9999, 5, "R10 R4 b2b");
    step(1, 128'h00000000000000000000000000000001, 128'h0, 1, "R10 R4 b2b");
    step(0, '0, '0, 0, "R9 hold after burst");

    // random mixture
    for (int i = 0; i < 60; i++) begin
      logic [127:0] s = {$urandom, $urandom, $urandom, $urandom};
      logic [127:0] k = {$urandom, $urandom, $urandom, $urandom};
      int r = $urandom_range(0, 10);
      bit v = ($urandom_range(0, 3) != 0);
      step(v, s, k, r, r == 0 ? "R3 random" : (r == 10 ? "R5 random" : "R4 random"));
    end

    // a second key and plaintext through the full chain
    round_trip({$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom});
    step(0, '0, '0, 0, "R9 final idle");

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule